// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets an on-chip host read and write an external asynchronous static RAM of 64K words by 16 bits. It runs on one system clock. It turns each host request into a strobe sequence on the RAM's active-low chip enable, write enable, output enable and the two byte enables. The host side is a request/ready handshake. A request carries an address, a write flag, a two-bit byte mask and write data. Read results come back with a one-cycle valid pulse.

Every access is timed in whole clock cycles. Three parameters set the lengths:

- `RD_CYC`: cycles the read window is held open.
- `WR_CYC`: cycles the write strobe is held low.
- `TA_CYC`: cycles of bus turnaround after a read.

Each parameter must be at least 1. Choose them from the clock period so that the RAM's access times are met: 12 ns address access and cycle time, and 6 ns output-enable access. The bidirectional data bus is split into three signals: an output, an output enable and an input. A pad cell outside the block joins them to the pins.

A write has three phases:

1. One setup cycle, with address, byte enables and data already presented.
2. The write strobe held low for `WR_CYC` cycles.
3. One hold cycle, in which data stays driven after the strobe rises, because the RAM captures the data on that rising edge.

The controller drives the data bus only while output enable is high. Every read ends with a turnaround in which all strobes are inactive, so the RAM's drivers are off before the controller can drive the bus.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `mem_be_n` is all ones and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for the whole access: `RD_CYC+TA_CYC` cycles for a read and `WR_CYC+2` cycles for a write. Whenever `req_ready` is 1, `mem_ce_n` is 1.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly `RD_CYC` cycles. `mem_dq_in` is sampled in the last of those cycles. `rd_valid` is 1 for exactly one cycle, the cycle right after the window closes, and `rd_data` holds its value afterwards.
- R4: A write gives one setup cycle with `mem_ce_n`=0 and `mem_we_n`=1. It then holds `mem_we_n`=0 for exactly `WR_CYC` cycles, then gives one hold cycle with `mem_ce_n`=0 and `mem_we_n`=1. `mem_oe_n` stays 1 throughout.
- R5: `mem_dq_oe` is 1 from the write setup cycle through the hold cycle. `mem_dq_out` and `mem_addr` do not change while `mem_we_n` rises, so the RAM stores `req_wdata`.
- R6: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0. Every read is followed by `TA_CYC` cycles in which all strobes are 1 and `mem_dq_oe` is 0.
- R7: During an access, `mem_be_n` equals the inverse of `req_mask`. Bit 0 is the lower byte (data bits 7:0) and bit 1 is the upper byte (bits 15:8). A write with a single-bit mask changes only that byte of the RAM word.
- R8: A write with `req_mask`=00 keeps both byte enables at 1 and leaves the RAM contents unchanged.
- R9: On a read, a byte lane whose mask bit is 0 returns 0 in `rd_data`. `mem_addr` equals `req_addr` for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_mask | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte, 1 = enabled |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| rd_data | output | 16 | Read result, disabled lanes zero |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte enables, bit 0 lower, bit 1 upper, active low |
| mem_addr | output | 16 | RAM address |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable of the data pad drivers |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
A sequencer stuck in a wrong state shows up at the ports within one access. `req_ready` returns high a cycle early or late, the write strobe or read window has the wrong length, or `rd_valid` pulses twice or not at all. A corrupted byte mask or stale write data leaves a wrong word in the RAM model, which the following read-back reports. A turnaround error shows as data drivers enabled in the same cycle as the RAM's output enable, and it is flagged in that cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_TURN  = 3'd2,
      ST_WSET  = 3'd3,
      ST_WPUL  = 3'd4,
      ST_WHLD  = 3'd5
   } seq_st_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drive;
   } strobe_t;

   localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

   function automatic strobe_t strobe_of(seq_st_e s);
      strobe_t r;
      r = STROBE_OFF;
      case (s)
         ST_RD:   begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
         ST_WSET: begin r.ce_n = 1'b0; r.drive = 1'b1; end
         ST_WPUL: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.drive = 1'b1; end
         ST_WHLD: begin r.ce_n = 1'b0; r.drive = 1'b1; end
         default: r = STROBE_OFF;
      endcase
      return r;
   endfunction

   function automatic logic in_access(seq_st_e s);
      return (s == ST_RD) || (s == ST_WSET) || (s == ST_WPUL) || (s == ST_WHLD);
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int RD_CYC = 2,
   parameter int WR_CYC = 2,
   parameter int TA_CYC = 1,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             is_write,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_st_e          state,
   output seq_st_e          state_nxt,
   output logic             capture
);
   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= state_nxt;
   end

   always_comb begin
      state_nxt = state;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      case (state)
         ST_IDLE: if (fire) begin
            if (is_write) begin
               state_nxt = ST_WSET;
            end else begin
               state_nxt = ST_RD;
               tmr_load  = 1'b1;
               tmr_val   = RD_LD;
            end
         end
         ST_RD: if (tmr_zero) begin
            state_nxt = ST_TURN;
            tmr_load  = 1'b1;
            tmr_val   = TA_LD;
         end
         ST_TURN: if (tmr_zero) state_nxt = ST_IDLE;
         ST_WSET: begin
            state_nxt = ST_WPUL;
            tmr_load  = 1'b1;
            tmr_val   = WR_LD;
         end
         ST_WPUL: if (tmr_zero) state_nxt = ST_WHLD;
         ST_WHLD: state_nxt = ST_IDLE;
         default: state_nxt = ST_IDLE;
      endcase
   end

   assign capture = (state == ST_RD) && tmr_zero;
endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [LANE_W-1:0] wr_byte,
   input  logic              capture,
   input  logic              lane_en,
   input  logic [LANE_W-1:0] pin_byte,
   output logic [LANE_W-1:0] drv_byte,
   output logic [LANE_W-1:0] rd_byte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_byte <= '0;
         rd_byte  <= '0;
      end else begin
         if (wr_load) drv_byte <= wr_byte;
         if (capture) rd_byte <= lane_en ? pin_byte : '0;
      end
   end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int LANE_W = 8,
   parameter int RD_CYC = 2,
   parameter int WR_CYC = 2,
   parameter int TA_CYC = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [AW-1:0]        req_addr,
   input  logic [DW/LANE_W-1:0] req_mask,
   input  logic [DW-1:0]        req_wdata,
   output logic                 rd_valid,
   output logic [DW-1:0]        rd_data,
   output logic                 mem_ce_n,
   output logic                 mem_we_n,
   output logic                 mem_oe_n,
   output logic [DW/LANE_W-1:0] mem_be_n,
   output logic [AW-1:0]        mem_addr,
   output logic [DW-1:0]        mem_dq_out,
   output logic                 mem_dq_oe,
   input  logic [DW-1:0]        mem_dq_in
);
   localparam int NB     = DW / LANE_W;
   localparam int MAXCYC = (RD_CYC > WR_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                             : ((WR_CYC > TA_CYC) ? WR_CYC : TA_CYC);
   localparam int CNT_W  = (MAXCYC < 2) ? 1 : $clog2(MAXCYC);

   if (RD_CYC < 1 || WR_CYC < 1 || TA_CYC < 1) begin : g_bad_cyc
      $error("sram_ctl: cycle counts must be at least 1");
   end
   if (DW % LANE_W != 0) begin : g_bad_lane
      $error("sram_ctl: data width must be a whole number of lanes");
   end

   seq_st_e          state, state_nxt;
   logic             fire, tmr_load, tmr_zero, capture;
   logic [CNT_W-1:0] tmr_val;
   strobe_t          strb_q;
   logic [NB-1:0]    mask_q, be_n_q;
   logic [AW-1:0]    addr_q;
   logic             rd_valid_q;

   assign req_ready = (state == ST_IDLE);
   assign fire      = req_valid && req_ready;

   sram_ctl_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   sram_ctl_seq #(
      .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(req_write),
      .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .state(state), .state_nxt(state_nxt), .capture(capture)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q     <= STROBE_OFF;
         mask_q     <= '0;
         be_n_q     <= '1;
         addr_q     <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         strb_q     <= strobe_of(state_nxt);
         rd_valid_q <= capture;
         if (fire) begin
            mask_q <= req_mask;
            addr_q <= req_addr;
         end
         if (in_access(state_nxt))
            be_n_q <= ~(fire ? req_mask : mask_q);
         else
            be_n_q <= '1;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      sram_ctl_lane #(.LANE_W(LANE_W)) lane_i (
         .clk(clk), .rst_n(rst_n),
         .wr_load(fire && req_write),
         .wr_byte(req_wdata[b*LANE_W +: LANE_W]),
         .capture(capture),
         .lane_en(mask_q[b]),
         .pin_byte(mem_dq_in[b*LANE_W +: LANE_W]),
         .drv_byte(mem_dq_out[b*LANE_W +: LANE_W]),
         .rd_byte(rd_data[b*LANE_W +: LANE_W])
      );
   end

   assign mem_ce_n  = strb_q.ce_n;
   assign mem_we_n  = strb_q.we_n;
   assign mem_oe_n  = strb_q.oe_n;
   assign mem_dq_oe = strb_q.drive;
   assign mem_be_n  = be_n_q;
   assign mem_addr  = addr_q;
   assign rd_valid  = rd_valid_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int NB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rd_valid,
   input logic          mem_ce_n,
   input logic          mem_we_n,
   input logic          mem_oe_n,
   input logic [NB-1:0] mem_be_n,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_dq_out,
   input logic          mem_dq_oe
);
   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (mem_be_n == '1)));
   // R2
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R3
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R3
   rd_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (mem_oe_n && $past(!mem_oe_n)));
   // R4
   we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe) && $stable(mem_addr)));
   // R4
   we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
   // R5
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out) && $stable(mem_addr) && $stable(mem_be_n)));
   // R6
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW), .NB(DW / LANE_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rd_valid(rd_valid), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
   .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
   localparam int RD = 3;
   localparam int WR = 2;
   localparam int TA = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] rd_data, mem_addr, mem_dq_out, mem_dq_in;

   int n_chk = 0, n_fail = 0;
   int cont_err = 0, idle_err = 0;
   int wl = 0, ol = 0;
   logic [15:0] ram [256];
   logic [15:0] shadow [256];

   always #10 clk = ~clk;

   sram_ctl #(.RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // RAM model: drives enabled lanes on read, disabled lanes show 8'hEE
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
      { mem_be_n[1] ? 8'hEE : ram[mem_addr[7:0]][15:8],
        mem_be_n[0] ? 8'hEE : ram[mem_addr[7:0]][7:0] } : 16'h0000;

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce_n) begin
         if (!mem_dq_oe) cont_err++;
         if (!mem_be_n[0]) ram[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
         if (!mem_be_n[1]) ram[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // pin monitor: strobe lengths, contention, idle chip enable
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !mem_oe_n) cont_err++;
         if (req_ready && !mem_ce_n) idle_err++;
         if (!mem_we_n) wl++;
         else if (wl != 0) begin
            chk(wl == WR, "R4 write strobe width", wl, WR);
            wl = 0;
         end
         if (!mem_oe_n) ol++;
         else if (ol != 0) begin
            chk(ol == RD, "R3 read window width", ol, RD);
            ol = 0;
         end
      end
   end

   task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] m,
                         input logic [15:0] d, output logic [15:0] rdat);
      int busy = 0, pulses = 0;
      bit first = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      rdat = '0;
      while (!req_ready) begin
         busy++;
         if (first) begin
            chk(mem_addr == a, "R9 address presented", mem_addr, a);
            chk(mem_be_n == ~m, "R7 byte enables", mem_be_n, ~m);
            first = 1'b0;
         end
         if (rd_valid) begin pulses++; rdat = rd_data; end
         @(negedge clk);
      end
      if (rd_valid) pulses++;
      chk(busy == (wr ? WR + 2 : RD + TA), "R2 busy length", busy, wr ? WR + 2 : RD + TA);
      if (!wr) chk(pulses == 1, "R3 read valid pulses", pulses, 1);
      else     chk(pulses == 0, "R3 no valid on write", pulses, 0);
   endtask

   function automatic logic [15:0] pat(int i, int k);
      return 16'((i * 40503 + k * 7919) ^ 16'h5A5A);
   endfunction

   function automatic logic [15:0] adr(int i);
      return {8'(i * 37 + 5), 8'(i)};
   endfunction

   initial begin
      logic [15:0] r, e;
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      chk(!mem_dq_oe && mem_be_n == 2'b11, "R1 bus off", {mem_dq_oe, mem_be_n}, 3'b011);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      rst_n = 1'b1;
      // full-word writes over every low address
      for (int i = 0; i < 256; i++) begin
         access(1'b1, adr(i), 2'b11, pat(i, 0), r);
         shadow[i] = pat(i, 0);
      end
      for (int i = 0; i < 256; i++) begin
         access(1'b0, adr(i), 2'b11, 16'h0, r);
         chk(r == shadow[i], "R5 full word read back", r, shadow[i]);
      end
      // byte-lane sweep: masks 01, 10, 00 over 64 words
      for (int i = 0; i < 64; i++) begin
         for (int mk = 0; mk < 3; mk++) begin
            logic [1:0] m;
            logic [15:0] d;
            m = (mk == 0) ? 2'b01 : (mk == 1) ? 2'b10 : 2'b00;
            d = pat(i, mk + 1);
            access(1'b1, adr(i), m, d, r);
            if (m[0]) shadow[i][7:0]  = d[7:0];
            if (m[1]) shadow[i][15:8] = d[15:8];
            access(1'b0, adr(i), 2'b11, 16'h0, r);
            if (m == 2'b00) chk(r == shadow[i], "R8 empty mask no change", r, shadow[i]);
            else            chk(r == shadow[i], "R7 single byte write", r, shadow[i]);
         end
      end
      // partial-lane reads: disabled lanes return zero
      for (int i = 0; i < 32; i++) begin
         for (int mk = 0; mk < 4; mk++) begin
            logic [1:0] m;
            m = 2'(mk);
            access(1'b0, adr(i), m, 16'h0, r);
            e = {m[1] ? shadow[i][15:8] : 8'h00, m[0] ? shadow[i][7:0] : 8'h00};
            chk(r == e, "R9 masked read lanes", r, e);
         end
      end
      // rd_data holds after the pulse
      access(1'b0, adr(3), 2'b11, 16'h0, r);
      repeat (4) @(negedge clk);
      chk(rd_data == shadow[3], "R3 rd_data held", rd_data, shadow[3]);
      chk(cont_err == 0, "R6 no bus contention", cont_err, 0);
      chk(idle_err == 0, "R2 chip enable high when idle", idle_err, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule